// File: doc/BRIEF.md
# LPC Host Cycle Engine

This block turns single-transfer requests from a Wishbone-style requester into host-side cycles on a 4-bit multiplexed low-pin-count bus with an active-low frame strobe. A request carries a two-bit kind tag, a direction, a 32-bit address and a write byte. The engine holds that request and walks a one-hot phase register through these phases: frame start, cycle type, address nibbles, optional write data, host turnaround, peripheral sync, optional read data and peripheral turnaround. It then closes the request with a one-clock acknowledge or a one-clock error.

Memory, I/O and firmware formats are supported, each for a single byte. The peripheral can stretch the sync phase with short-wait and long-wait codes. A short wait that runs too long causes an abort. An error sync code is reported back to the requester. The bidirectional LAD bus is split into a driven value, an output enable and a sampled input, so that the pad can sit at the chip edge.

Top module: `lpc_host_engine`

## Requirements
- R1: On the first clock after a request is accepted, frame_n is low and LAD is driven with 4'b0000 for memory and I/O cycles, 4'b1101 for a firmware read, and 4'b1110 for a firmware write. frame_n is high in every other phase except an abort.
- R2: Memory and I/O cycles follow the start with one cycle-type nibble {class[1:0], write, 1'b0}. The class is 2'b00 for I/O and 2'b01 for memory. Firmware cycles have no cycle-type nibble.
- R3: I/O cycles send the 4 nibbles of addr[15:0], most significant first. Memory cycles send the 8 nibbles of addr[31:0], most significant first. Firmware cycles send addr[31:28] as the device-select nibble, then the 7 nibbles of addr[27:0], most significant first, then a size nibble of 4'b0000.
- R4: Writes send the data byte in 2 clocks, bits [3:0] first and then bits [7:4].
- R5: The host turnaround drives LAD = 4'hF for one clock and then releases LAD (output enable low) for one clock.
- R6: During sync the output enable is low. LAD-in 4'b0110 (long wait) and 4'b0101 (short wait) keep the engine in sync, and so does any code other than ready or error. 4'b0000 (ready) ends the sync phase.
- R7: After a ready sync on a read, the engine samples two nibbles, low nibble first. The byte appears on req_rdata by the time the acknowledge is given.
- R8: The peripheral turnaround lasts two clocks with LAD released. On the next clock, req_ack is high for exactly one clock and req_err stays low.
- R9: Sync code 4'b1010 ends the sync phase, skips read data, runs the peripheral turnaround, and then raises req_err for one clock instead of req_ack.
- R10: Eight short-wait clocks (or unrecognised-code clocks) are tolerated in one sync phase. On the ninth, the cycle is aborted: frame_n low with LAD = 4'b1111 for 4 clocks, then req_err for one clock.
- R11: Kind tag 2'b11 (channel transfer) is rejected. The next clock gives req_err for one clock, and frame_n and LAD stay idle.
- R12: After reset and between cycles, frame_n is high, LAD is released, and req_ack and req_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, held until acknowledge or error |
| req_we | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 00 memory, 01 I/O, 10 firmware, 11 channel transfer (rejected) |
| req_addr | input | 32 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-clock completion pulse |
| req_err | output | 1 | One-clock error pulse |
| req_rdata | output | 8 | Read byte |
| lframe_n | output | 1 | Active-low frame strobe |
| lad_out | output | 4 | Value driven onto LAD |
| lad_oe | output | 1 | LAD output enable |
| lad_in | input | 4 | Value sampled from LAD |

## Verification
Each of the three cycle formats is run in both directions. This tells apart the three start codes, the presence or absence of the cycle-type and size nibbles, and the 4-nibble and 8-nibble address lengths. Sync streams mix short waits, long waits, an error code, exactly eight short waits followed by ready, and nine short waits. These separate the wait handling from the timeout boundary and from the error path. A channel-kind request shows that rejection happens without any bus activity, and distinct read bytes expose nibble-order swaps.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

    localparam int ADDR_BITS = 32;
    localparam int DATA_BITS = 8;

    typedef enum logic [1:0] {
        KIND_MEM = 2'b00,
        KIND_IO  = 2'b01,
        KIND_FW  = 2'b10,
        KIND_CHN = 2'b11
    } lpc_kind_e;

    localparam logic [3:0] CODE_START_STD = 4'b0000;
    localparam logic [3:0] CODE_START_FWR = 4'b1101;
    localparam logic [3:0] CODE_START_FWW = 4'b1110;
    localparam logic [3:0] CODE_ABORT     = 4'b1111;
    localparam logic [3:0] CODE_TAR       = 4'hF;
    localparam logic [3:0] CODE_SIZE_BYTE = 4'b0000;
    localparam logic [3:0] SYNC_READY     = 4'b0000;
    localparam logic [3:0] SYNC_LONG      = 4'b0110;
    localparam logic [3:0] SYNC_ERROR     = 4'b1010;

    typedef enum logic [13:0] {
        ST_IDLE   = 14'h0001,
        ST_START  = 14'h0002,
        ST_CYCTYP = 14'h0004,
        ST_ADDR   = 14'h0008,
        ST_SIZE   = 14'h0010,
        ST_HDATA  = 14'h0020,
        ST_HTAR1  = 14'h0040,
        ST_HTAR2  = 14'h0080,
        ST_SYNC   = 14'h0100,
        ST_PDATA  = 14'h0200,
        ST_PTAR1  = 14'h0400,
        ST_PTAR2  = 14'h0800,
        ST_ABORT  = 14'h1000,
        ST_DONE   = 14'h2000
    } lpc_state_e;

    typedef enum logic [1:0] {
        SC_READY,
        SC_LONG,
        SC_SHORT,
        SC_ERROR
    } sync_class_e;

    typedef struct packed {
        lpc_kind_e              kind;
        logic                   we;
        logic [ADDR_BITS-1:0]   addr;
        logic [DATA_BITS-1:0]   wdata;
    } lpc_req_t;

    function automatic logic [3:0] start_code(lpc_kind_e kind, logic we);
        if (kind == KIND_FW) return we ? CODE_START_FWW : CODE_START_FWR;
        return CODE_START_STD;
    endfunction

    function automatic logic [3:0] cyctype_code(lpc_kind_e kind, logic we);
        return {(kind == KIND_IO) ? 2'b00 : 2'b01, we, 1'b0};
    endfunction

    function automatic sync_class_e classify_sync(logic [3:0] code);
        case (code)
            SYNC_READY: return SC_READY;
            SYNC_LONG:  return SC_LONG;
            SYNC_ERROR: return SC_ERROR;
            default:    return SC_SHORT;
        endcase
    endfunction

    function automatic logic [2:0] last_addr_nibble(lpc_kind_e kind);
        return (kind == KIND_IO) ? 3'd3 : 3'd7;
    endfunction

endpackage

// File: rtl/lpc_field_mux.sv
module lpc_field_mux
    import lpc_host_pkg::*;
(
    input  lpc_state_e  state,
    input  lpc_req_t    req,
    input  logic [2:0]  nib_cnt,
    output logic        lframe_n,
    output logic [3:0]  lad_out,
    output logic        lad_oe
);
    logic [2:0] addr_idx;
    logic [4:0] addr_off;

    always_comb begin
        addr_idx = last_addr_nibble(req.kind) - nib_cnt;
        addr_off = {addr_idx, 2'b00};
    end

    always_comb begin
        lframe_n = 1'b1;
        lad_out  = CODE_TAR;
        lad_oe   = 1'b0;
        case (state)
            ST_START: begin
                lframe_n = 1'b0;
                lad_oe   = 1'b1;
                lad_out  = start_code(req.kind, req.we);
            end
            ST_CYCTYP: begin
                lad_oe  = 1'b1;
                lad_out = cyctype_code(req.kind, req.we);
            end
            ST_ADDR: begin
                lad_oe  = 1'b1;
                lad_out = req.addr[addr_off +: 4];
            end
            ST_SIZE: begin
                lad_oe  = 1'b1;
                lad_out = CODE_SIZE_BYTE;
            end
            ST_HDATA: begin
                lad_oe  = 1'b1;
                lad_out = nib_cnt[0] ? req.wdata[7:4] : req.wdata[3:0];
            end
            ST_HTAR1: begin
                lad_oe  = 1'b1;
                lad_out = CODE_TAR;
            end
            ST_ABORT: begin
                lframe_n = 1'b0;
                lad_oe   = 1'b1;
                lad_out  = CODE_ABORT;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch
    import lpc_host_pkg::*;
#(
    parameter int SWAIT_MAX = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_sync,
    input  logic [3:0]  lad_in,
    output sync_class_e cls,
    output logic        timeout
);
    localparam int CNT_W = $clog2(SWAIT_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(SWAIT_MAX);

    logic [CNT_W-1:0] swait_cnt;

    always_comb begin
        cls     = classify_sync(lad_in);
        timeout = in_sync && (cls == SC_SHORT) && (swait_cnt == CNT_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst || !in_sync) begin
            swait_cnt <= '0;
        end else if (cls == SC_SHORT && swait_cnt != CNT_LIMIT) begin
            swait_cnt <= swait_cnt + 1'b1;
        end
    end

    AST_SWAIT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        swait_cnt <= CNT_LIMIT); // R10
    AST_CNT_CLEARS_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        !in_sync |=> (swait_cnt == '0)); // R10
endmodule

// File: rtl/lpc_rdata_capture.sv
module lpc_rdata_capture
    import lpc_host_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap_en,
    input  logic                 cap_hi,
    input  logic [3:0]           lad_in,
    output logic [DATA_BITS-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (cap_en) begin
            if (cap_hi) rdata[7:4] <= lad_in;
            else        rdata[3:0] <= lad_in;
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(rdata)); // R7
endmodule

// File: rtl/lpc_host_engine.sv
module lpc_host_engine
    import lpc_host_pkg::*;
#(
    parameter int SWAIT_MAX    = 8,
    parameter int ABORT_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_we,
    input  logic [1:0]  req_kind,
    input  logic [31:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        req_ack,
    output logic        req_err,
    output logic [7:0]  req_rdata,
    output logic        lframe_n,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    input  logic [3:0]  lad_in
);
    localparam int ABORT_W = (ABORT_CYCLES > 1) ? $clog2(ABORT_CYCLES) : 1;
    localparam logic [ABORT_W-1:0] ABORT_LAST = ABORT_W'(ABORT_CYCLES - 1);

    lpc_state_e        state, state_nx;
    lpc_req_t          req_q;
    logic [2:0]        nib_cnt, nib_cnt_nx;
    logic [ABORT_W-1:0] abort_cnt, abort_cnt_nx;
    logic              err_flag, err_flag_nx;
    sync_class_e       sync_cls;
    logic              sync_timeout;
    lpc_kind_e         kind_in;

    assign kind_in = lpc_kind_e'(req_kind);

    lpc_field_mux u_field_mux (
        .state    (state),
        .req      (req_q),
        .nib_cnt  (nib_cnt),
        .lframe_n (lframe_n),
        .lad_out  (lad_out),
        .lad_oe   (lad_oe)
    );

    lpc_sync_watch #(.SWAIT_MAX(SWAIT_MAX)) u_sync_watch (
        .clk     (clk),
        .rst     (rst),
        .in_sync (state == ST_SYNC),
        .lad_in  (lad_in),
        .cls     (sync_cls),
        .timeout (sync_timeout)
    );

    lpc_rdata_capture u_rdata_capture (
        .clk    (clk),
        .rst    (rst),
        .cap_en (state == ST_PDATA),
        .cap_hi (nib_cnt[0]),
        .lad_in (lad_in),
        .rdata  (req_rdata)
    );

    always_comb begin
        state_nx     = state;
        nib_cnt_nx   = nib_cnt;
        abort_cnt_nx = abort_cnt;
        err_flag_nx  = err_flag;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (kind_in == KIND_CHN) begin
                        state_nx    = ST_DONE;
                        err_flag_nx = 1'b1;
                    end else begin
                        state_nx    = ST_START;
                        err_flag_nx = 1'b0;
                    end
                end
            end
            ST_START: begin
                nib_cnt_nx = '0;
                state_nx   = (req_q.kind == KIND_FW) ? ST_ADDR : ST_CYCTYP;
            end
            ST_CYCTYP: state_nx = ST_ADDR;
            ST_ADDR: begin
                if (nib_cnt == last_addr_nibble(req_q.kind)) begin
                    nib_cnt_nx = '0;
                    if (req_q.kind == KIND_FW) state_nx = ST_SIZE;
                    else                       state_nx = req_q.we ? ST_HDATA : ST_HTAR1;
                end else begin
                    nib_cnt_nx = nib_cnt + 3'd1;
                end
            end
            ST_SIZE:  state_nx = req_q.we ? ST_HDATA : ST_HTAR1;
            ST_HDATA: begin
                if (nib_cnt[0]) begin
                    nib_cnt_nx = '0;
                    state_nx   = ST_HTAR1;
                end else begin
                    nib_cnt_nx = 3'd1;
                end
            end
            ST_HTAR1: state_nx = ST_HTAR2;
            ST_HTAR2: state_nx = ST_SYNC;
            ST_SYNC: begin
                if (sync_timeout) begin
                    abort_cnt_nx = '0;
                    err_flag_nx  = 1'b1;
                    state_nx     = ST_ABORT;
                end else if (sync_cls == SC_READY) begin
                    nib_cnt_nx = '0;
                    state_nx   = req_q.we ? ST_PTAR1 : ST_PDATA;
                end else if (sync_cls == SC_ERROR) begin
                    err_flag_nx = 1'b1;
                    state_nx    = ST_PTAR1;
                end
            end
            ST_PDATA: begin
                if (nib_cnt[0]) begin
                    nib_cnt_nx = '0;
                    state_nx   = ST_PTAR1;
                end else begin
                    nib_cnt_nx = 3'd1;
                end
            end
            ST_PTAR1: state_nx = ST_PTAR2;
            ST_PTAR2: state_nx = ST_DONE;
            ST_ABORT: begin
                if (abort_cnt == ABORT_LAST) state_nx = ST_DONE;
                else abort_cnt_nx = abort_cnt + 1'b1;
            end
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            nib_cnt   <= '0;
            abort_cnt <= '0;
            err_flag  <= 1'b0;
            req_q     <= '0;
        end else begin
            state     <= state_nx;
            nib_cnt   <= nib_cnt_nx;
            abort_cnt <= abort_cnt_nx;
            err_flag  <= err_flag_nx;
            if (state == ST_IDLE && req_valid) begin
                req_q <= '{kind: kind_in, we: req_we, addr: req_addr, wdata: req_wdata};
            end
        end
    end

    assign req_ack = (state == ST_DONE) && !err_flag;
    assign req_err = (state == ST_DONE) &&  err_flag;

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(state)); // R12
    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(req_ack && req_err)); // R9
    AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (req_ack || req_err) |=> !(req_ack || req_err)); // R8
    AST_FRAME_DRIVES_LAD: assert property (@(posedge clk) disable iff (rst)
        !lframe_n |-> lad_oe); // R1
    AST_RELEASE_AFTER_TAR: assert property (@(posedge clk) disable iff (rst)
        (lad_oe && state == ST_HTAR1) |=> !lad_oe); // R5
    AST_TIMEOUT_ABORTS: assert property (@(posedge clk) disable iff (rst)
        sync_timeout |=> (!lframe_n && lad_out == CODE_ABORT)); // R10
    AST_CHAN_REJECT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && req_kind == 2'b11) |=> (req_err && lframe_n)); // R11
endmodule

// File: tb/lpc_host_engine_bench.sv
module lpc_host_engine_bench;
    localparam int CLK_P = 10;
    localparam int ABORT_N = 4;
    localparam int SW_MAX = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_we;
    logic [1:0]  req_kind;
    logic [31:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ack, req_err;
    logic [7:0]  req_rdata;
    logic        lframe_n, lad_oe;
    logic [3:0]  lad_out, lad_in;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic       fr;
        logic       oe;
        logic [3:0] lad;
        logic       ack;
        logic       err;
        logic       chk_rd;
        logic [7:0] rd;
        logic [3:0] drv;
        string      tag;
    } exp_t;

    exp_t       q[$];
    logic [3:0] sync_q[$];

    always #(CLK_P/2) clk = ~clk;

    lpc_host_engine u_lpc_host_engine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
        .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in)
    );

    function automatic void put(logic fr, logic oe, logic [3:0] lad, logic ack,
                                logic err, logic [3:0] drv, string tag);
        exp_t e;
        e.fr = fr; e.oe = oe; e.lad = lad; e.ack = ack; e.err = err;
        e.chk_rd = 1'b0; e.rd = 8'h00; e.drv = drv; e.tag = tag;
        q.push_back(e);
    endfunction

    // monitor: pops one expected item per clock and drives the peripheral nibble
    initial begin
        lad_in = 4'hF;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (lframe_n !== e.fr || lad_oe !== e.oe || (e.oe && lad_out !== e.lad) ||
                    req_ack !== e.ack || req_err !== e.err ||
                    (e.chk_rd && req_rdata !== e.rd)) begin
                    fails++;
                    $display("FAIL %s: got fr=%b oe=%b lad=%h ack=%b err=%b rd=%h exp fr=%b oe=%b lad=%h ack=%b err=%b rd=%h",
                             e.tag, lframe_n, lad_oe, lad_out, req_ack, req_err, req_rdata,
                             e.fr, e.oe, e.lad, e.ack, e.err, e.rd);
                end
                lad_in = e.drv;
            end
        end
    end

    // driver: builds the expected bus trace from the requirements, then issues the request
    task automatic run(logic [1:0] kind, logic we, logic [31:0] addr,
                       logic [7:0] wd, logic [7:0] rd);
        int sw = 0;
        int outcome = 0; // 0 ready, 1 error sync, 2 timeout
        int n;
        @(posedge clk);
        #(CLK_P/4);
        put(1, 0, 4'hF, 0, 0, 4'hF, "R12 idle");
        if (kind == 2'b11) begin
            put(1, 0, 4'hF, 0, 1, 4'hF, "R11 reject");
        end else begin
            if (kind == 2'b10) put(0, 1, we ? 4'b1110 : 4'b1101, 0, 0, 4'hF, "R1 start");
            else begin
                put(0, 1, 4'b0000, 0, 0, 4'hF, "R1 start");
                put(1, 1, {(kind == 2'b01) ? 2'b00 : 2'b01, we, 1'b0}, 0, 0, 4'hF, "R2 cyctype");
            end
            n = (kind == 2'b01) ? 4 : 8;
            for (int i = n - 1; i >= 0; i--) put(1, 1, addr[i*4 +: 4], 0, 0, 4'hF, "R3 addr");
            if (kind == 2'b10) put(1, 1, 4'h0, 0, 0, 4'hF, "R3 size");
            if (we) begin
                put(1, 1, wd[3:0], 0, 0, 4'hF, "R4 data lo");
                put(1, 1, wd[7:4], 0, 0, 4'hF, "R4 data hi");
            end
            put(1, 1, 4'hF, 0, 0, 4'hF, "R5 tar drive");
            put(1, 0, 4'hF, 0, 0, 4'hF, "R5 tar release");
            foreach (sync_q[k]) begin
                logic [3:0] c;
                c = sync_q[k];
                put(1, 0, 4'hF, 0, 0, c, "R6 sync");
                if (c == 4'b0000) begin outcome = 0; break; end
                if (c == 4'b1010) begin outcome = 1; break; end
                if (c != 4'b0110) begin
                    if (sw == SW_MAX) begin outcome = 2; break; end
                    sw++;
                end
            end
            if (outcome == 2) begin
                for (int i = 0; i < ABORT_N; i++) put(0, 1, 4'hF, 0, 0, 4'hF, "R10 abort");
                put(1, 0, 4'hF, 0, 1, 4'hF, "R10 err");
            end else begin
                if (outcome == 0 && !we) begin
                    put(1, 0, 4'hF, 0, 0, rd[3:0], "R7 rd lo");
                    put(1, 0, 4'hF, 0, 0, rd[7:4], "R7 rd hi");
                end
                put(1, 0, 4'hF, 0, 0, 4'hF, "R8 ptar1");
                put(1, 0, 4'hF, 0, 0, 4'hF, "R8 ptar2");
                if (outcome == 1) put(1, 0, 4'hF, 0, 1, 4'hF, "R9 err");
                else begin
                    put(1, 0, 4'hF, 1, 0, 4'hF, "R8 ack");
                    if (!we) begin
                        q[q.size()-1].chk_rd = 1'b1;
                        q[q.size()-1].rd = rd;
                        q[q.size()-1].tag = "R7 rdata";
                    end
                end
            end
        end
        req_kind = kind; req_we = we; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        wait (q.size() == 0);
        req_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req_valid = 0; req_we = 0; req_kind = 0; req_addr = 0; req_wdata = 0;
        repeat (3) @(posedge clk);
        #(CLK_P/4) rst = 1'b0;
        @(negedge clk);
        checks++;
        if (lframe_n !== 1'b1 || lad_oe !== 1'b0 || req_ack !== 1'b0 || req_err !== 1'b0) begin
            fails++;
            $display("FAIL R12 reset: fr=%b oe=%b ack=%b err=%b exp 1 0 0 0",
                     lframe_n, lad_oe, req_ack, req_err);
        end
        sync_q = '{4'b0101, 4'b0101, 4'b0000};
        run(2'b01, 0, 32'h1234_5678, 8'h00, 8'hA5);   // I/O read
        sync_q = '{4'b0000};
        run(2'b01, 1, 32'h0000_9ABC, 8'h3C, 8'h00);   // I/O write
        sync_q = '{4'b0110, 4'b0110, 4'b0110, 4'b0000};
        run(2'b00, 0, 32'hDEAD_BEEF, 8'h00, 8'h7E);   // memory read
        sync_q = '{4'b0101, 4'b0000};
        run(2'b00, 1, 32'h0123_4567, 8'hC9, 8'h00);   // memory write
        sync_q = '{4'b0000};
        run(2'b10, 0, 32'h5ABC_DEF1, 8'h00, 8'h96);   // firmware read
        sync_q = '{4'b0101, 4'b0000};
        run(2'b10, 1, 32'hA765_4321, 8'h81, 8'h00);   // firmware write
        sync_q = '{4'b0000};
        run(2'b11, 0, 32'h0000_0010, 8'h00, 8'h00);   // channel kind rejected
        sync_q = '{4'b0101, 4'b1010};
        run(2'b01, 0, 32'h0000_0060, 8'h00, 8'h00);   // error sync
        sync_q = {};
        for (int i = 0; i < SW_MAX + 1; i++) sync_q.push_back(4'b0101);
        run(2'b00, 0, 32'h0000_1000, 8'h00, 8'h00);   // timeout
        sync_q = {};
        for (int i = 0; i < SW_MAX; i++) sync_q.push_back(4'b0101);
        sync_q.push_back(4'b0000);
        run(2'b00, 0, 32'h0000_2000, 8'h00, 8'h3D);   // boundary: eight waits pass
        sync_q = {};
        for (int i = 0; i < 20; i++) sync_q.push_back(4'b0110);
        sync_q.push_back(4'b0000);
        run(2'b01, 1, 32'h0000_0080, 8'h5A, 8'h00);   // long waits never time out
        sync_q = {4'b1111, 4'b0110, 4'b0000};
        run(2'b00, 0, 32'h0000_3000, 8'h00, 8'hE1);   // unrecognised code waits
        @(posedge clk);
        #(CLK_P/4);
        put(1, 0, 4'hF, 0, 0, 4'hF, "R12 idle after");
        wait (q.size() == 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule